// File: doc/BRIEF.md
# Reserved-Store Link Monitor

This block is the per-processor reservation logic behind a linked-load / conditional-store pair. A linked load reads a word from the block's local memory and, in the same step, records which block of memory it touched and marks that reservation live. A later conditional store writes its data only if the reservation is still live and covers the addressed block. The store answers one bit: 1 when the write happened, 0 when it was dropped.

The reservation does not depend only on matching addresses. Other agents can kill it. A snoop port reports writes or invalidations made by other agents, and an interrupt/context-switch line reports that the pair was split by a change of thread. Either event clears the reservation. Software builds atomic swap, fetch-and-add and similar operations by retrying the pair until the conditional store reports success.

Every request gets a registered response one clock later. The memory is a single-port synchronous array that can map onto block RAM.

Top module: `llsc_monitor`

## Requirements
- R1: Each clock with `req_valid` high yields `rsp_valid` high on the next clock, and a clock with `req_valid` low yields `rsp_valid` low. Synchronous reset drives `rsp_valid` and `rsp_sc_ok` to 0 and drops any reservation.
- R2: `req_op` encodes 0 = no operation, 1 = load, 2 = store, 3 = linked load, 4 = conditional store. A linked load returns the word at `req_addr` on `rsp_rdata` with its response. Codes 0, 5, 6 and 7 write nothing, leave the reservation untouched, and respond with `rsp_sc_ok` = 0.
- R3: A linked load records the block `req_addr[AW-1:2]` (four words per block) and makes the reservation live. A conditional store to any word of that block while the reservation is live writes `req_wdata` and responds with `rsp_sc_ok` = 1.
- R4: A conditional store with no live reservation, or to a block other than the reserved one, leaves memory unchanged and responds with `rsp_sc_ok` = 0.
- R5: Every conditional store clears the reservation, whether it succeeds or fails, so a second conditional store with no new linked load fails.
- R6: `irq_evt` clears the reservation. A conditional store presented in the same clock as `irq_evt` fails.
- R7: `snoop_valid` with `snoop_addr` in the reserved block clears the reservation. A snoop to another block has no effect. A snoop that hits the store's block in the same clock makes that conditional store fail.
- R8: A plain store to the reserved block clears the reservation. A plain store to another block leaves it live.
- R9: A new linked load replaces the earlier reservation, so only the latest linked block can be stored to.
- R10: A plain store writes `req_wdata` at `req_addr`. A later load returns the last value written there, whether by a plain store or by a successful conditional store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this clock |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| snoop_valid | input | 1 | Another agent wrote or invalidated `snoop_addr` |
| snoop_addr | input | AW | Word address seen on the snoop port |
| irq_evt | input | 1 | Interrupt or context switch this clock |
| rsp_valid | output | 1 | Response to the previous clock's request |
| rsp_rdata | output | DW | Read data for a load or linked load |
| rsp_sc_ok | output | 1 | Conditional store result: 1 = written, 0 = dropped |

## Verification
A reservation that stays live when it should have been cleared shows up as a wrongly reported success. It is visible on `rsp_sc_ok` exactly one clock after the next conditional store, and the memory also holds a value it should not, which the following load exposes. A reservation that is wrongly cleared, or a wrong recorded block, shows as a failure reported on that same cycle. The stimulus therefore places every clearing event (interrupt, snoop, own store, failed store, successful store, new linked load) between a linked load and a conditional store. Each such event has a control case that must still succeed.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_LINK  = 3'd3,
    OP_COND  = 3'd4
  } op_e;
endpackage

// File: rtl/llsc_decode.sv
module llsc_decode
  import llsc_pkg::*;
(
  input  logic       req_valid,
  input  logic [2:0] req_op,
  output logic       is_load,
  output logic       is_store,
  output logic       is_link,
  output logic       is_cond
);
  op_e op;
  assign op = op_e'(req_op);

  always_comb begin
    is_load  = 1'b0;
    is_store = 1'b0;
    is_link  = 1'b0;
    is_cond  = 1'b0;
    if (req_valid) begin
      unique case (op)
        OP_LOAD:  is_load  = 1'b1;
        OP_STORE: is_store = 1'b1;
        OP_LINK:  is_link  = 1'b1;
        OP_COND:  is_cond  = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/llsc_resv.sv
module llsc_resv #(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_en,
  input  logic          store_en,
  input  logic          cond_en,
  input  logic [BW-1:0] req_blk,
  input  logic          snoop_valid,
  input  logic [BW-1:0] snoop_blk,
  input  logic          irq_evt,
  output logic          cond_pass
);
  logic          live_q, live_d;
  logic [BW-1:0] blk_q, blk_d;

  // Conditional store wins only on a live, matching, undisturbed reservation.
  always_comb begin
    cond_pass = cond_en && live_q && (blk_q == req_blk) && !irq_evt &&
                !(snoop_valid && (snoop_blk == req_blk));
  end

  // Set first, then apply every clearing cause on top.
  always_comb begin
    live_d = live_q;
    blk_d  = blk_q;
    if (link_en) begin
      live_d = 1'b1;
      blk_d  = req_blk;
    end
    if (cond_en) live_d = 1'b0;
    if (store_en && (req_blk == blk_d)) live_d = 1'b0;
    if (snoop_valid && (snoop_blk == blk_d)) live_d = 1'b0;
    if (irq_evt) live_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      blk_q  <= '0;
    end else begin
      live_q <= live_d;
      blk_q  <= blk_d;
    end
  end
endmodule

// File: rtl/llsc_ram.sv
module llsc_ram #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int BLK_W = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  input  logic          irq_evt,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_sc_ok
);
  localparam int BW = AW - BLK_W;

  logic is_load, is_store, is_link, is_cond;
  logic cond_pass;
  logic mem_we;

  llsc_decode u_dec (
    .req_valid (req_valid),
    .req_op    (req_op),
    .is_load   (is_load),
    .is_store  (is_store),
    .is_link   (is_link),
    .is_cond   (is_cond)
  );

  llsc_resv #(.BW(BW)) u_resv (
    .clk         (clk),
    .rst         (rst),
    .link_en     (is_link),
    .store_en    (is_store),
    .cond_en     (is_cond),
    .req_blk     (req_addr[AW-1:BLK_W]),
    .snoop_valid (snoop_valid),
    .snoop_blk   (snoop_addr[AW-1:BLK_W]),
    .irq_evt     (irq_evt),
    .cond_pass   (cond_pass)
  );

  assign mem_we = is_store || cond_pass;

  llsc_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .addr  (req_addr),
    .wdata (req_wdata),
    .rdata (rsp_rdata)
  );

  logic unused_load;
  assign unused_load = is_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_sc_ok <= cond_pass;
    end
  end
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk
  import llsc_pkg::*;
#(
  parameter int AW    = 6,
  parameter int BLK_W = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic [2:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic          snoop_valid,
  input logic [AW-1:0] snoop_addr,
  input logic          irq_evt,
  input logic          rsp_valid,
  input logic          rsp_sc_ok
);
  logic cond_req;
  assign cond_req = req_valid && (req_op == OP_COND);

  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r1_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r4_ok_only_for_cond: assert property (@(posedge clk) disable iff (rst)
    !cond_req |=> !rsp_sc_ok);

  a_r5_second_cond_fails: assert property (@(posedge clk) disable iff (rst)
    cond_req ##1 cond_req |=> !rsp_sc_ok);

  a_r6_irq_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (cond_req && irq_evt) |=> !rsp_sc_ok);

  a_r6_irq_then_cond: assert property (@(posedge clk) disable iff (rst)
    irq_evt ##1 cond_req |=> !rsp_sc_ok);

  a_r7_snoop_same_cycle: assert property (@(posedge clk) disable iff (rst)
    (cond_req && snoop_valid &&
     (snoop_addr[AW-1:BLK_W] == req_addr[AW-1:BLK_W])) |=> !rsp_sc_ok);
endmodule

bind llsc_monitor llsc_monitor_chk #(.AW(AW), .BLK_W(BLK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .snoop_valid (snoop_valid),
  .snoop_addr  (snoop_addr),
  .irq_evt     (irq_evt),
  .rsp_valid   (rsp_valid),
  .rsp_sc_ok   (rsp_sc_ok)
);

// File: tb/sim_llsc_monitor.sv
module sim_llsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int DW = 32;

  localparam logic [2:0] N  = 3'd0;
  localparam logic [2:0] LD = 3'd1;
  localparam logic [2:0] ST = 3'd2;
  localparam logic [2:0] LL = 3'd3;
  localparam logic [2:0] SC = 3'd4;

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          snv;
    logic [AW-1:0] sna;
    logic          irq;
    logic          chk_rd;
    logic          exp_ok;
    logic [DW-1:0] exp_rd;
    logic [3:0]    tag;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t TAB [NV] = '{
    '{ST, 6'd8,  32'h11, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd10}, // R10
    '{ST, 6'd20, 32'h22, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd10}, // R10
    '{LD, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h11, 4'd10}, // R10
    '{LL, 6'd9,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd3},  // R3
    '{SC, 6'd10, 32'hA0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 32'h0,  4'd3},  // R3 other word, same block
    '{LD, 6'd10, 32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'hA0, 4'd3},  // R3 write landed
    '{SC, 6'd10, 32'hB0, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd5},  // R5 success cleared it
    '{LD, 6'd10, 32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'hA0, 4'd4},  // R4 no write
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h11, 4'd2},  // R2 link returns data
    '{SC, 6'd20, 32'h55, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd4},  // R4 wrong block
    '{LD, 6'd20, 32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h22, 4'd4},  // R4 memory unchanged
    '{SC, 6'd8,  32'h56, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd5},  // R5 failure cleared it
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd6},
    '{N,  6'd0,  32'h0,  1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 32'h0,  4'd6},  // R6 interrupt between
    '{SC, 6'd8,  32'h66, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd6},
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd6},
    '{SC, 6'd8,  32'h66, 1'b0, 6'd0,  1'b1, 1'b0, 1'b0, 32'h0,  4'd6},  // R6 same clock
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd7},
    '{N,  6'd0,  32'h0,  1'b1, 6'd11, 1'b0, 1'b0, 1'b0, 32'h0,  4'd7},  // R7 snoop hit
    '{SC, 6'd8,  32'h67, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd7},
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd7},
    '{N,  6'd0,  32'h0,  1'b1, 6'd12, 1'b0, 1'b0, 1'b0, 32'h0,  4'd7},  // R7 snoop elsewhere
    '{SC, 6'd8,  32'h77, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 32'h0,  4'd7},
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd7},
    '{SC, 6'd9,  32'h5B, 1'b1, 6'd8,  1'b0, 1'b0, 1'b0, 32'h0,  4'd7},  // R7 snoop wins
    '{LD, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h77, 4'd7},
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h77, 4'd8},
    '{ST, 6'd21, 32'h33, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd8},  // R8 other block
    '{SC, 6'd8,  32'h88, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 32'h0,  4'd8},
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd8},
    '{ST, 6'd10, 32'h44, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd8},  // R8 same block
    '{SC, 6'd8,  32'h99, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd8},
    '{LD, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h88, 4'd10}, // R10
    '{LD, 6'd10, 32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h44, 4'd10}, // R10
    '{LL, 6'd8,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd9},
    '{LL, 6'd20, 32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h22, 4'd9},
    '{SC, 6'd8,  32'h12, 1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd9},  // R9 old link gone
    '{LL, 6'd20, 32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd9},
    '{SC, 6'd21, 32'h5A, 1'b0, 6'd0,  1'b0, 1'b0, 1'b1, 32'h0,  4'd9},
    '{LD, 6'd21, 32'h0,  1'b0, 6'd0,  1'b0, 1'b1, 1'b0, 32'h5A, 4'd9},
    '{N,  6'd0,  32'h0,  1'b0, 6'd0,  1'b0, 1'b0, 1'b0, 32'h0,  4'd2}   // R2 no-op responds
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          snoop_valid;
  logic [AW-1:0] snoop_addr;
  logic          irq_evt;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_sc_ok;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  llsc_monitor #(.AW(AW), .DW(DW), .BLK_W(2)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .irq_evt(irq_evt), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok)
  );

  task automatic idle();
    req_valid = 1'b0; req_op = N; req_addr = '0; req_wdata = '0;
    snoop_valid = 1'b0; snoop_addr = '0; irq_evt = 1'b0;
  endtask

  task automatic check1(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive one request for one clock, then sample its response at the next falling edge.
  task automatic step(input vec_t v, input int idx);
    req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_wdata = v.wdata;
    snoop_valid = v.snv; snoop_addr = v.sna; irq_evt = v.irq;
    @(negedge clk);
    idle();
    n_run++;
    if (rsp_valid !== 1'b1 || rsp_sc_ok !== v.exp_ok ||
        (v.chk_rd && rsp_rdata !== v.exp_rd)) begin
      n_fail++;
      $display("FAIL vector %0d R%0d actual valid=%0b ok=%0b rd=%0h expected valid=1 ok=%0b rd=%0h",
               idx, v.tag, rsp_valid, rsp_sc_ok, rsp_rdata, v.exp_ok, v.exp_rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check1("R1 reset rsp_valid", DW'(rsp_valid), '0);
    check1("R1 reset rsp_sc_ok", DW'(rsp_sc_ok), '0);

    for (int i = 0; i < NV; i++) step(TAB[i], i);

    // R1 idle clock gives no response
    @(negedge clk);
    check1("R1 idle rsp_valid", DW'(rsp_valid), '0);

    // R1 reset drops a live reservation
    step('{LL, 6'd4, 32'h0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd1}, 100);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    step('{SC, 6'd4, 32'hC3, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd1}, 101);

    // R2 unused op code 7 leaves the reservation live and writes nothing
    step('{LL, 6'd4, 32'h0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd2}, 102);
    step('{3'd7, 6'd4, 32'hEE, 1'b0, 6'd0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd2}, 103);
    step('{SC, 6'd5, 32'hC4, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 32'h0, 4'd2}, 104);
    step('{LD, 6'd5, 32'h0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 32'hC4, 4'd2}, 105);

    // R3 back-to-back link and conditional store with no idle clock
    req_valid = 1'b1; req_op = LL; req_addr = 6'd40; req_wdata = '0;
    @(negedge clk);
    req_op = SC; req_wdata = 32'hD1;
    @(negedge clk);
    idle();
    check1("R3 back-to-back sc_ok", DW'(rsp_sc_ok), DW'(1));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule